// File: doc/BRIEF.md
# Line Brownout Qualifier

This block watches a stream of digitized line-magnitude samples and decides whether the supply line is in brownout. Each sample arrives with a valid strobe. It is compared against two programmable levels: a low trip level used while running, and a higher recovery level used while stopped. The gap between the two levels gives hysteresis in amplitude. A qualification timer gives hysteresis in time, so a dip or a recovery must last a full window before the state changes.

The timer counts slow ticks derived from the system clock by a parameterized prescaler (`CLK_HZ / TICK_HZ` clock cycles per tick). A window is `QUAL_TICKS` ticks; with a 1 ms tick and 56 ticks this is about seven rectified half-cycles of a 60 Hz line. While in brownout the block holds the gate drive off and requests standby. It keeps evaluating samples so that it can recover on its own. After reset it starts in brownout, so switching is only allowed once a healthy line has been seen for a full window.

Top module: `line_sag_guard`

## Requirements
- R1: While reset is applied and directly after it, the block is in brownout: `gate_off` and `standby_req` are both 1. The two outputs always carry the same value.
- R2: In the running state (`gate_off`=0), when every sample is strictly below `thr_low`, `gate_off` rises between (QUAL_TICKS-1)*D+2 and QUAL_TICKS*D+1 clock cycles after the first such sample is registered, where D = CLK_HZ/TICK_HZ.
- R3: In the running state, any accepted sample at or above `thr_low` restarts the entry window, so a dip shorter than the window never causes brownout.
- R4: Samples inside the band `thr_low` <= level <= `thr_high` change neither state: they do not cause entry while running and do not cause exit while in brownout. Equality with either level counts as inside the band.
- R5: In brownout, when every sample is strictly above `thr_high`, `gate_off` falls within the same cycle window as in R2, measured from the first such sample.
- R6: In brownout, any accepted sample at or below `thr_high` restarts the exit window.
- R7: `level` is taken only in cycles where `valid` is 1. Between strobes the timer keeps running on the result of the most recent accepted sample.
- R8: The qualification count never exceeds QUAL_TICKS, and it is zero directly after every state change.
- R9: The prescaler emits a single-cycle tick once every D clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid | input | 1 | Sample strobe; `level` is accepted when 1 |
| level | input | LEVEL_W | Line magnitude sample |
| thr_low | input | LEVEL_W | Trip level for entering brownout |
| thr_high | input | LEVEL_W | Recovery level for leaving brownout |
| gate_off | output | 1 | 1 while in brownout; forces the gate drive off |
| standby_req | output | 1 | 1 while in brownout; requests low-power standby |

## Verification
The bench targets the timing window edges. A design that counted too few ticks would flip before the lower bound, and one that counted too many would still be unflipped at the upper bound. It interrupts a long low run with a single healthy sample, then does the same to a long high run with one sample exactly equal to the recovery level. A design that failed to restart its window would flip early, and one that used the wrong comparison at equality would also flip early. It holds samples exactly on each level and inside the band for longer than a window, which catches swapped or non-strict comparisons. It also drops `level` to zero with the strobe low, which exposes a design that samples without the strobe or stops timing between strobes.

// File: rtl/sag_pkg.sv
package sag_pkg;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_BROWN = 1'b1
    } sag_state_e;

    typedef struct packed {
        logic below;
        logic above;
    } sag_cmp_t;

endpackage

// File: rtl/sag_tick_gen.sv
module sag_tick_gen #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV - 1);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } tick_reg_t;

    tick_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (r_q.cnt == LAST) begin
            r_d.cnt = '0;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign tick = (r_q.cnt == LAST);

endmodule

// File: rtl/sag_level_cmp.sv
module sag_level_cmp
    import sag_pkg::*;
#(
    parameter int LEVEL_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid,
    input  logic [LEVEL_W-1:0] level,
    input  logic [LEVEL_W-1:0] thr_low,
    input  logic [LEVEL_W-1:0] thr_high,
    output logic               below,
    output logic               above
);
    sag_cmp_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (valid) begin
            r_d.below = (level < thr_low);
            r_d.above = (level > thr_high);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign below = r_q.below;
    assign above = r_q.above;

endmodule

// File: rtl/sag_qual_timer.sv
module sag_qual_timer #(
    parameter int QUAL_TICKS = 56,
    parameter int CNT_W      = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             tick,
    input  logic             clear,
    output logic             done,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(QUAL_TICKS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } qual_reg_t;

    qual_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clear || !arm) begin
            r_d.cnt = '0;
        end else if (tick && (r_q.cnt < LIMIT)) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign done  = arm && (r_q.cnt == LIMIT);
    assign count = r_q.cnt;

endmodule

// File: rtl/line_sag_guard.sv
module line_sag_guard
    import sag_pkg::*;
#(
    parameter int LEVEL_W    = 12,
    parameter int CLK_HZ     = 50_000_000,
    parameter int TICK_HZ    = 1000,
    parameter int QUAL_TICKS = 56
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid,
    input  logic [LEVEL_W-1:0] level,
    input  logic [LEVEL_W-1:0] thr_low,
    input  logic [LEVEL_W-1:0] thr_high,
    output logic               gate_off,
    output logic               standby_req
);
    localparam int DIV   = CLK_HZ / TICK_HZ;
    localparam int CNT_W = $clog2(QUAL_TICKS + 1);

    typedef struct packed {
        sag_state_e state;
    } fsm_reg_t;

    logic             tick;
    logic             below;
    logic             above;
    logic             arm;
    logic             done;
    logic [CNT_W-1:0] qual_cnt;
    fsm_reg_t         r_d, r_q;

    sag_tick_gen #(
        .DIV (DIV)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    sag_level_cmp #(
        .LEVEL_W (LEVEL_W)
    ) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (valid),
        .level    (level),
        .thr_low  (thr_low),
        .thr_high (thr_high),
        .below    (below),
        .above    (above)
    );

    // Pick the condition that qualifies a change from the current state.
    always_comb begin
        arm = (r_q.state == ST_RUN) ? below : above;
    end

    sag_qual_timer #(
        .QUAL_TICKS (QUAL_TICKS),
        .CNT_W      (CNT_W)
    ) u_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (arm),
        .tick  (tick),
        .clear (done),
        .done  (done),
        .count (qual_cnt)
    );

    always_comb begin
        r_d = r_q;
        if (done) begin
            r_d.state = (r_q.state == ST_RUN) ? ST_BROWN : ST_RUN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_BROWN;
        end else begin
            r_q <= r_d;
        end
    end

    assign gate_off    = (r_q.state == ST_BROWN);
    assign standby_req = (r_q.state == ST_BROWN);

endmodule

// File: rtl/sag_guard_checker.sv
module sag_guard_checker #(
    parameter int QUAL_TICKS = 56,
    parameter int CNT_W      = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             gate_off,
    input logic             standby_req,
    input logic             below,
    input logic             above,
    input logic             tick,
    input logic [CNT_W-1:0] qual_cnt
);
    a_r1_reset_brown: assert property (@(posedge clk) !rst_n |=> gate_off);

    a_r1_outputs_agree: assert property (@(posedge clk) disable iff (!rst_n)
        gate_off == standby_req);

    a_r2_entry_armed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_off) |-> $past(below));

    a_r5_exit_armed: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_off) |-> $past(above));

    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        qual_cnt <= CNT_W'(QUAL_TICKS));

    a_r8_clear_on_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_off != $past(gate_off)) |-> (qual_cnt == '0));

    a_r9_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

bind line_sag_guard sag_guard_checker #(
    .QUAL_TICKS (QUAL_TICKS),
    .CNT_W      (CNT_W)
) u_sag_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .gate_off    (gate_off),
    .standby_req (standby_req),
    .below       (below),
    .above       (above),
    .tick        (tick),
    .qual_cnt    (qual_cnt)
);

// File: tb/test_line_sag_guard.sv
module test_line_sag_guard;
    localparam int CLK_PERIOD = 10;
    localparam int LW   = 12;
    localparam int CHZ  = 800;
    localparam int THZ  = 100;
    localparam int QT   = 5;
    localparam int D    = CHZ / THZ;
    localparam int TMIN = (QT - 1) * D + 2;   // earliest flip
    localparam int TMAX = QT * D + 1;         // latest flip
    localparam int EARLY = TMIN - 2;
    localparam int LATE  = TMAX + 3;

    localparam logic [LW-1:0] LOW_T  = 12'd100;
    localparam logic [LW-1:0] HIGH_T = 12'd130;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          valid = 1'b0;
    logic [LW-1:0] level = '0;
    logic [LW-1:0] thr_low = LOW_T;
    logic [LW-1:0] thr_high = HIGH_T;
    logic          gate_off;
    logic          standby_req;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    line_sag_guard #(
        .LEVEL_W    (LW),
        .CLK_HZ     (CHZ),
        .TICK_HZ    (THZ),
        .QUAL_TICKS (QT)
    ) i_line_sag_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid       (valid),
        .level       (level),
        .thr_low     (thr_low),
        .thr_high    (thr_high),
        .gate_off    (gate_off),
        .standby_req (standby_req)
    );

    task automatic check(input string req, input logic exp);
        checks++;
        if (gate_off !== exp || standby_req !== exp) begin
            errors++;
            $display("FAIL %s gate_off=%b standby_req=%b expected=%b at %0t",
                     req, gate_off, standby_req, exp, $time);
        end
    endtask

    // Drive a strobed sample every cycle for n cycles (inputs change at negedge).
    task automatic apply(input logic [LW-1:0] v, input int n);
        valid = 1'b1;
        level = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 in reset", 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 1'b1);
    endtask

    task automatic t_exit();
        apply(12'd200, EARLY);
        check("R5 exit not before window", 1'b1);
        apply(12'd200, LATE - EARLY);
        check("R5 R9 exit after window", 1'b0);
    endtask

    task automatic t_entry_dip();
        apply(12'd50, EARLY);
        apply(LOW_T, 1);                 // equal to trip level restarts window
        apply(12'd50, EARLY);
        check("R3 dip restarted entry window", 1'b0);
        apply(12'd50, LATE - EARLY);
        check("R2 entry after full window", 1'b1);
    endtask

    task automatic t_exit_restart();
        apply(12'd200, EARLY);
        apply(HIGH_T, 1);                // equal to recovery level restarts window
        apply(12'd200, EARLY);
        check("R6 exit window restarted", 1'b1);
        apply(12'd200, LATE - EARLY);
        check("R6 exit after restart", 1'b0);
    endtask

    task automatic t_band();
        apply(LOW_T, 3 * LATE);
        check("R4 level equal thr_low stays running", 1'b0);
        apply(12'd115, 3 * LATE);
        check("R4 in-band stays running", 1'b0);
        apply(12'd50, LATE);
        check("R2 entry from band", 1'b1);
        apply(12'd115, 3 * LATE);
        check("R4 in-band stays brownout", 1'b1);
        apply(HIGH_T, 3 * LATE);
        check("R4 level equal thr_high stays brownout", 1'b1);
    endtask

    task automatic t_strobe();
        apply(12'd200, 1);
        valid = 1'b0;
        level = 12'd0;
        repeat (LATE) @(negedge clk);
        check("R7 timer runs between strobes", 1'b0);
        repeat (3 * LATE) @(negedge clk);
        check("R7 level ignored without strobe", 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_exit();
        t_entry_dip();
        t_exit_restart();
        t_band();
        t_strobe();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule